// File: doc/BRIEF.md
# Floating-Point Condition Branch and Move Decoder

This block sits beside the floating-point coprocessor's issue logic. It takes one instruction word per strobe, along with the sequential program counter that follows it, the current floating-point condition flag and three privilege bits. One cycle later it reports what that word asks of the rest of the core. The word may be a branch on the condition flag, with or without annulment of its delay slot. It may be a conditional register copy that tests the condition flag or an integer register. It may also need an exception raised. The register files, the program counter and the pipeline belong to the core; this unit only decides.

Checks run in a fixed order. The coprocessor-enable test comes first and covers every coprocessor word. The extended-instruction gate comes next and applies only in user mode. Decode runs only when both checks pass. At most one exception request leaves the block per word.

Top module: `fcb_unit`

## Requirements
- R1: All results are registered. A strobe at a clock edge gives `out_valid` high and the decoded results on the next edge. A cycle without a strobe gives all outputs zero, and reset clears every output.
- R2: Some words need the coprocessor: major opcode 0x11 (any form), major opcode 0x13, or major opcode 0x00 with function 0x01. If `cu1_en` is low when such a word arrives, only `exc_cpu` is raised, with `exc_ce` = 1. This check wins over every other check.
- R3: A condition branch has major opcode 0x11 and bits [25:21] = 0x08. Bit 16 is the sense. The branch is taken when bit 16 equals `fcc`, and `br_target` is then `npc` plus the 16-bit immediate shifted left by two and sign-extended from 18 bits.
- R4: An ordinary branch (bit 17 = 0) that is not taken raises only `br_not_taken`. `slot_skip` stays low and both address outputs stay zero.
- R5: A likely branch (bit 17 = 1) that is not taken raises `br_not_taken` and `slot_skip`, with `skip_pc` = `npc` + 4.
- R6: A taken likely branch behaves like a taken ordinary branch: no slot skip.
- R7: Major 0x11 with format 0x10 or 0x11 and function 0x11 is a copy on the condition flag. `mv_en` is high when bit 16 equals `fcc`. Any other format with that function does nothing.
- R8: Major 0x11 with format 0x10 or 0x11 and function 0x12 raises `mv_en` when `rt_zero` is high. Function 0x13 raises it when `rt_zero` is low.
- R9: In user mode with `xisa_en` low, the copies of R7 and R8 and every major-0x13 word raise only `exc_ii`. In kernel mode, or when `xisa_en` is high, no exception is raised and the word decodes normally.
- R10: Major 0x00 with function 0x01 copies an integer register on the condition flag: `mv_en` is high when bit 16 equals `fcc`. This copy is not subject to the extended-instruction gate.
- R11: At most one exception output is high per word. Other coprocessor-1 arithmetic words, and words outside R2's list, produce no request at all, even when `cu1_en` is low for the latter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction strobe |
| ins_word | input | 32 | Instruction word |
| npc | input | PCW | Address following the instruction |
| fcc | input | 1 | Floating-point condition flag |
| cu1_en | input | 1 | Coprocessor 1 enabled |
| user_mode | input | 1 | Core is in user mode |
| xisa_en | input | 1 | Extended instructions allowed in user mode |
| rt_zero | input | 1 | Selected integer register equals zero |
| out_valid | output | 1 | Results valid for the strobed word |
| br_taken | output | 1 | Branch taken |
| br_not_taken | output | 1 | Branch not taken |
| br_target | output | PCW | Taken target, zero otherwise |
| slot_skip | output | 1 | Annul the delay slot |
| skip_pc | output | PCW | Address past the delay slot, zero otherwise |
| mv_en | output | 1 | Perform the conditional copy |
| exc_cpu | output | 1 | Coprocessor-unusable request |
| exc_ce | output | 2 | Coprocessor number for the cause register |
| exc_ii | output | 1 | Illegal-instruction request |

## Verification
The bench builds the block with the default 32-bit address width. This puts the full sign extension of the offset within reach, including the most negative offset and a target that wraps below address zero. A table walked back to back covers every decode class under each privilege combination. Directed cases check the reset state and the return to zero outputs after a gap in the strobe.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

    localparam logic [5:0] OPC_COP1    = 6'h11;
    localparam logic [5:0] OPC_COP1X   = 6'h13;
    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [4:0] FMT_BRANCH  = 5'h08;
    localparam logic [4:0] FMT_SGL     = 5'h10;
    localparam logic [4:0] FMT_DBL     = 5'h11;
    localparam logic [5:0] FN_MOVCF    = 6'h11;
    localparam logic [5:0] FN_MOVZ     = 6'h12;
    localparam logic [5:0] FN_MOVN     = 6'h13;
    localparam logic [5:0] FN_INT_MOVC = 6'h01;
    localparam logic [1:0] CE_COP1     = 2'd1;

    typedef enum logic [2:0] {
        K_NONE,
        K_BRANCH,
        K_FMOVC,
        K_FMOVZ,
        K_FMOVN,
        K_FUSED,
        K_IMOVC,
        K_OTHER
    } kind_e;

    typedef struct packed {
        logic       valid;
        logic       taken;
        logic       not_taken;
        logic       skip;
        logic       mv;
        logic       cpu;
        logic [1:0] ce;
        logic       ii;
    } flags_t;

endpackage

// File: rtl/fcb_decode.sv
module fcb_decode
    import fcb_pkg::*;
(
    input  logic [31:0] ins,
    output kind_e       kind,
    output logic        sense,
    output logic        likely,
    output logic        gated
);
    logic [5:0] major;
    logic [4:0] fmt;
    logic [5:0] fn;
    logic       fp_fmt;

    assign major  = ins[31:26];
    assign fmt    = ins[25:21];
    assign fn     = ins[5:0];
    assign sense  = ins[16];
    assign likely = ins[17];
    assign fp_fmt = (fmt == FMT_SGL) || (fmt == FMT_DBL);

    always_comb begin
        kind = K_NONE;
        if (major == OPC_COP1) begin
            if (fmt == FMT_BRANCH)                  kind = K_BRANCH;
            else if (fp_fmt && fn == FN_MOVCF)      kind = K_FMOVC;
            else if (fp_fmt && fn == FN_MOVZ)       kind = K_FMOVZ;
            else if (fp_fmt && fn == FN_MOVN)       kind = K_FMOVN;
            else                                    kind = K_OTHER;
        end else if (major == OPC_COP1X) begin
            kind = K_FUSED;
        end else if (major == OPC_SPECIAL && fn == FN_INT_MOVC) begin
            kind = K_IMOVC;
        end
    end

    assign gated = (kind == K_FMOVC) || (kind == K_FMOVZ) ||
                   (kind == K_FMOVN) || (kind == K_FUSED);

endmodule

// File: rtl/fcb_target.sv
module fcb_target #(
    parameter int PCW = 32
) (
    input  logic [PCW-1:0] npc,
    input  logic [15:0]    imm,
    output logic [PCW-1:0] tgt,
    output logic [PCW-1:0] seq
);
    localparam int OFSW = 18;
    localparam int EXTW = PCW - OFSW;

    logic [OFSW-1:0] ofs18;
    logic [PCW-1:0]  ofs;

    assign ofs18 = {imm, 2'b00};

    generate
        if (EXTW > 0) begin : g_wide
            assign ofs = {{EXTW{ofs18[OFSW-1]}}, ofs18};
        end else begin : g_narrow
            assign ofs = ofs18[PCW-1:0];
        end
    endgenerate

    assign tgt = npc + ofs;
    assign seq = npc + PCW'(4);

endmodule

// File: rtl/fcb_unit.sv
module fcb_unit
    import fcb_pkg::*;
#(
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_valid,
    input  logic [31:0]    ins_word,
    input  logic [PCW-1:0] npc,
    input  logic           fcc,
    input  logic           cu1_en,
    input  logic           user_mode,
    input  logic           xisa_en,
    input  logic           rt_zero,
    output logic           out_valid,
    output logic           br_taken,
    output logic           br_not_taken,
    output logic [PCW-1:0] br_target,
    output logic           slot_skip,
    output logic [PCW-1:0] skip_pc,
    output logic           mv_en,
    output logic           exc_cpu,
    output logic [1:0]     exc_ce,
    output logic           exc_ii
);
    typedef struct packed {
        flags_t         f;
        logic [PCW-1:0] tgt;
        logic [PCW-1:0] skp;
    } state_t;

    state_t st_d, st_q;

    kind_e          kind;
    logic           sense, likely, gated;
    logic [PCW-1:0] tgt_c, seq_c;

    fcb_decode u_dec (
        .ins    (ins_word),
        .kind   (kind),
        .sense  (sense),
        .likely (likely),
        .gated  (gated)
    );

    fcb_target #(.PCW(PCW)) u_tgt (
        .npc (npc),
        .imm (ins_word[15:0]),
        .tgt (tgt_c),
        .seq (seq_c)
    );

    always_comb begin
        st_d = '0;
        if (ins_valid) begin
            st_d.f.valid = 1'b1;
            if (kind != K_NONE && !cu1_en) begin
                st_d.f.cpu = 1'b1;
                st_d.f.ce  = CE_COP1;
            end else if (gated && user_mode && !xisa_en) begin
                st_d.f.ii = 1'b1;
            end else begin
                unique case (kind)
                    K_BRANCH: begin
                        if (sense == fcc) begin
                            st_d.f.taken = 1'b1;
                            st_d.tgt     = tgt_c;
                        end else begin
                            st_d.f.not_taken = 1'b1;
                            if (likely) begin
                                st_d.f.skip = 1'b1;
                                st_d.skp    = seq_c;
                            end
                        end
                    end
                    K_FMOVC, K_IMOVC: st_d.f.mv = (sense == fcc);
                    K_FMOVZ:          st_d.f.mv = rt_zero;
                    K_FMOVN:          st_d.f.mv = !rt_zero;
                    default:          st_d.f.mv = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.f.valid;
    assign br_taken     = st_q.f.taken;
    assign br_not_taken = st_q.f.not_taken;
    assign br_target    = st_q.tgt;
    assign slot_skip    = st_q.f.skip;
    assign skip_pc      = st_q.skp;
    assign mv_en        = st_q.f.mv;
    assign exc_cpu      = st_q.f.cpu;
    assign exc_ce       = st_q.f.ce;
    assign exc_ii       = st_q.f.ii;

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> !(out_valid || br_taken || br_not_taken || mv_en || exc_cpu || exc_ii)); // R1
    AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !cu1_en && ins_word[31:26] == OPC_COP1) |=> (exc_cpu && !exc_ii)); // R2
    AST_CPU_CE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cpu |-> (exc_ce == CE_COP1)); // R2
    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_cpu || exc_ii) |-> !(br_taken || br_not_taken || slot_skip || mv_en)); // R2
    AST_BR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_taken && br_not_taken)); // R3
    AST_SKIP_NT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_skip |-> br_not_taken); // R5
    AST_ONE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({exc_cpu, exc_ii}) <= 1); // R11

endmodule

// File: tb/tb_fcb_unit.sv
module tb_fcb_unit;
    localparam int PCW = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ins_valid;
    logic [31:0]    ins_word;
    logic [PCW-1:0] npc;
    logic           fcc, cu1_en, user_mode, xisa_en, rt_zero;
    logic           out_valid, br_taken, br_not_taken, slot_skip, mv_en, exc_cpu, exc_ii;
    logic [PCW-1:0] br_target, skip_pc;
    logic [1:0]     exc_ce;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fcb_unit #(.PCW(PCW)) dut (.*);

    // ctl = {fcc, cu1_en, user_mode, xisa_en, rt_zero}
    // exp = {taken, not_taken, skip, mv, cpu, ii}
    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] pc;
        logic [4:0]  ctl;
        logic [5:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{32'h45010004, 32'h00001000, 5'b11000, 6'b100000, 8'd3},  // R3 true-sense taken
        '{32'h4501FFFF, 32'h00002000, 5'b11000, 6'b100000, 8'd3},  // R3 negative offset
        '{32'h45000010, 32'h00003000, 5'b01000, 6'b100000, 8'd3},  // R3 false-sense taken
        '{32'h45018000, 32'h00100000, 5'b11000, 6'b100000, 8'd3},  // R3 most negative offset
        '{32'h4500FFFE, 32'h00000004, 5'b01000, 6'b100000, 8'd3},  // R3 wrap below zero
        '{32'h45017FFF, 32'h00000000, 5'b11110, 6'b100000, 8'd3},  // R3 largest offset, user
        '{32'h45010004, 32'h00001000, 5'b01000, 6'b010000, 8'd4},  // R4 ordinary not taken
        '{32'h45000004, 32'h00001000, 5'b11000, 6'b010000, 8'd4},  // R4 false-sense not taken
        '{32'h45030008, 32'h00004000, 5'b01000, 6'b011000, 8'd5},  // R5 likely true not taken
        '{32'h45020008, 32'h00005000, 5'b11000, 6'b011000, 8'd5},  // R5 likely false not taken
        '{32'h45030008, 32'h00006000, 5'b11000, 6'b100000, 8'd6},  // R6 likely taken
        '{32'h45020008, 32'h00007000, 5'b01000, 6'b100000, 8'd6},  // R6 likely false taken
        '{32'h45010004, 32'h00001000, 5'b10000, 6'b000010, 8'd2},  // R2 branch, cop off
        '{32'h46010011, 32'h0, 5'b11000, 6'b000100, 8'd7},          // R7 movt.s flag set
        '{32'h46010011, 32'h0, 5'b01000, 6'b000000, 8'd7},          // R7 movt.s flag clear
        '{32'h46200011, 32'h0, 5'b01000, 6'b000100, 8'd7},          // R7 movf.d flag clear
        '{32'h46800011, 32'h0, 5'b11000, 6'b000000, 8'd7},          // R7 other format ignored
        '{32'h46000012, 32'h0, 5'b01001, 6'b000100, 8'd8},          // R8 movz zero
        '{32'h46000012, 32'h0, 5'b01000, 6'b000000, 8'd8},          // R8 movz nonzero
        '{32'h46200013, 32'h0, 5'b01000, 6'b000100, 8'd8},          // R8 movn nonzero
        '{32'h46010011, 32'h0, 5'b11100, 6'b000001, 8'd9},          // R9 user gated move
        '{32'h46010011, 32'h0, 5'b11110, 6'b000100, 8'd9},          // R9 user enabled move
        '{32'h4C000020, 32'h0, 5'b01100, 6'b000001, 8'd9},          // R9 fused user gated
        '{32'h4C000020, 32'h0, 5'b01000, 6'b000000, 8'd9},          // R9 fused kernel
        '{32'h4C000020, 32'h0, 5'b00100, 6'b000010, 8'd2},          // R2 priority over gate
        '{32'h00010001, 32'h0, 5'b11100, 6'b000100, 8'd10},         // R10 int move ungated
        '{32'h00010001, 32'h0, 5'b00000, 6'b000010, 8'd2},          // R2 int move, cop off
        '{32'h00000001, 32'h0, 5'b11000, 6'b000000, 8'd10},         // R10 sense mismatch
        '{32'h46000000, 32'h0, 5'b01000, 6'b000000, 8'd11},         // R11 arithmetic word
        '{32'h8C000000, 32'h0, 5'b00000, 6'b000000, 8'd11}          // R11 foreign word
    };

    function automatic logic [PCW-1:0] exp_tgt(input logic [31:0] w, input logic [PCW-1:0] p);
        return p + {{(PCW-18){w[15]}}, w[15:0], 2'b00};
    endfunction

    task automatic check(input int req, input logic [75:0] act, input logic [75:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [75:0] outs();
        return {out_valid, br_taken, br_not_taken, slot_skip, mv_en, exc_cpu, exc_ii,
                exc_ce, br_target, skip_pc};
    endfunction

    task automatic drive(input vec_t v);
        ins_valid = 1'b1;
        ins_word  = v.ins;
        npc       = v.pc;
        {fcc, cu1_en, user_mode, xisa_en, rt_zero} = v.ctl;
    endtask

    function automatic logic [75:0] expect_of(input vec_t v);
        logic [PCW-1:0] t, s;
        t = v.exp[5] ? exp_tgt(v.ins, v.pc) : '0;
        s = v.exp[3] ? v.pc + PCW'(4) : '0;
        return {1'b1, v.exp, (v.exp[1] ? 2'd1 : 2'd0), t, s};
    endfunction

    initial begin
        rst_n = 1'b0; ins_valid = 1'b1; ins_word = 32'h45010004; npc = 32'h100;
        fcc = 1'b1; cu1_en = 1'b1; user_mode = 1'b0; xisa_en = 1'b0; rt_zero = 1'b0;
        repeat (3) @(negedge clk);
        check(1, outs(), 76'd0); // R1 reset state while strobe held
        rst_n = 1'b1;
        ins_valid = 1'b0;
        @(negedge clk);
        check(1, outs(), 76'd0); // R1 no strobe after reset

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check(int'(TBL[i].req), outs(), expect_of(TBL[i]));
        end

        // R1: gap in strobe clears a previous taken result
        drive(TBL[0]);
        @(negedge clk);
        ins_valid = 1'b0;
        @(negedge clk);
        check(1, outs(), 76'd0); // R1 gap

        // R1: back-to-back words each land one cycle later
        drive(TBL[8]);
        @(negedge clk);
        check(5, outs(), expect_of(TBL[8]));
        drive(TBL[21]);
        @(negedge clk);
        check(9, outs(), expect_of(TBL[21]));
        ins_valid = 1'b0;
        @(negedge clk);
        check(1, outs(), 76'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule